// File: doc/BRIEF.md
# Hot-Swap Power Sequencing Controller

This block decides when the supply switches of a plug-in card may turn on. It watches two active-low connection-sense contacts, an active-low power-on-reset request and a set of digitised comparator flags. For each rail there is a flag for undervoltage lockout, one for overcurrent, and one that reports the switched output has decayed below its re-power level. From these it drives a single charge-pump enable and an active-low circuit-breaker fault output.

A card that is being inserted must show both contacts low, continuously, for a full qualification interval before power is applied. Losing either contact removes power at once. Overcurrent trips a breaker latch that only a reset request clears. A reset request held for the qualification interval becomes a hard reset that turns the rails off. After a hard reset or a cleared trip, power returns only once every output has decayed and a fresh qualification has finished. All inputs are asynchronous and pass through two-flop synchronisers. The interval is a count of ticks, and a tick is a fixed number of clocks.

Top module: `hsw_seq_ctrl`

## Requirements
- R1: During and after reset, with no card present, `pump_en` is 0 and `fault_n` is 1.
- R2: `pump_en` rises only after both `conn_a_n` and `conn_b_n` have been low for QUAL_TICKS*TICK_DIV clocks. It is high no later than that count plus 4 clocks, and it is not high 20 clocks after the inputs go low in the bench configuration.
- R3: A high pulse on either connection input during qualification restarts the interval from zero.
- R4: While powered, either connection input going high drops `pump_en` within 3 clocks.
- R5: Any bit of `uvlo_flag` set to 1 drops `pump_en` within 3 clocks and blocks qualification for as long as it stays set. Bit i is the lockout flag of rail i.
- R6: While powered, any bit of `ocp_flag` set to 1 drives `fault_n` to 0 and `pump_en` to 0 within 4 clocks. Both hold after the overcurrent flag clears.
- R7: `por_req_n` going low clears the breaker latch, and `fault_n` returns to 1 within 4 clocks, with no qualification delay.
- R8: A `por_req_n` low pulse shorter than the qualification interval leaves a powered card powered.
- R9: `por_req_n` held low for the qualification interval drops `pump_en` within 4 clocks of that interval. `pump_en` stays 0 while the request stays low.
- R10: After a hard reset, power returns only once `por_req_n` is high and every bit of `out_low_flag` is 1, where 1 means the output is below its re-power level. A new qualification interval follows.
- R11: After a trip is cleared, the same discharge interlock and full requalification apply before `pump_en` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conn_a_n | input | 1 | First connection-sense contact, low when mated |
| conn_b_n | input | 1 | Second connection-sense contact, low when mated |
| por_req_n | input | 1 | Power-on-reset request, active low |
| uvlo_flag | input | NUM_RAILS | Per-rail undervoltage lockout flag, 1 = below lockout |
| ocp_flag | input | NUM_RAILS | Per-rail overcurrent flag, 1 = overcurrent |
| out_low_flag | input | NUM_RAILS | Per-rail flag, 1 = switched output below re-power level |
| pump_en | output | 1 | Charge-pump enable for the rail switches |
| fault_n | output | 1 | Breaker fault, low while the latch is tripped |

## Verification
The bench builds the block with TICK_DIV=4 and QUAL_TICKS=5, so each qualification interval lasts 20 clocks instead of a million. This makes it practical to probe both sides of the threshold and to restart qualification with a glitch. It can also hold a short reset pulse well inside the window and then let a hard reset and a full requalification run back to back. Holding times of 40 clocks, twice the interval, show that the latch and the discharge interlock do not release on their own.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_QUALIFY   = 3'd1,
    ST_RAMP_ON   = 3'd2,
    ST_FAULTED   = 3'd3,
    ST_DISCHARGE = 3'd4,
    ST_WAIT_TRIP = 3'd5
  } hsw_state_e;
endpackage

// File: rtl/hsw_sync.sv
module hsw_sync #(
  parameter int               WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/hsw_qual_timer.sv
module hsw_qual_timer #(
  parameter int TICK_DIV   = 50000,
  parameter int QUAL_TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  output logic done_o
);
  localparam int DIV_W = $clog2(TICK_DIV + 1);
  localparam int CNT_W = $clog2(QUAL_TICKS + 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign done_o = (cnt_q == CNT_W'(QUAL_TICKS));
  assign cnt_en = active_i && !done_o;

  always_comb begin
    div_d = div_q;
    cnt_d = cnt_q;
    if (!active_i) begin
      div_d = '0;
      cnt_d = '0;
    end else if (cnt_en) begin
      if (div_q == DIV_W'(TICK_DIV - 1)) begin
        div_d = '0;
        cnt_d = cnt_q + CNT_W'(1);
      end else begin
        div_d = div_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end

  AST_DONE_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(active_i)); // R2
  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(QUAL_TICKS)); // R2
endmodule

// File: rtl/hsw_breaker.sv
module hsw_breaker (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic trip_o
);
  logic trip_q, trip_d;

  always_comb begin
    trip_d = trip_q;
    if (clr_i)      trip_d = 1'b0;
    else if (set_i) trip_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trip_q <= 1'b0;
    else        trip_q <= trip_d;
  end

  assign trip_o = trip_q;

  AST_TRIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_o && !clr_i) |=> trip_o); // R6
  AST_TRIP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !trip_o); // R7
endmodule

// File: rtl/hsw_seq_ctrl.sv
module hsw_seq_ctrl
  import hsw_pkg::*;
#(
  parameter int NUM_RAILS  = 2,
  parameter int TICK_DIV   = 50000,
  parameter int QUAL_TICKS = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 conn_a_n,
  input  logic                 conn_b_n,
  input  logic                 por_req_n,
  input  logic [NUM_RAILS-1:0] uvlo_flag,
  input  logic [NUM_RAILS-1:0] ocp_flag,
  input  logic [NUM_RAILS-1:0] out_low_flag,
  output logic                 pump_en,
  output logic                 fault_n
);
  localparam int SW = 3 + 3 * NUM_RAILS;
  localparam logic [SW-1:0] SYNC_RST =
    {3'b111, {NUM_RAILS{1'b1}}, {NUM_RAILS{1'b0}}, {NUM_RAILS{1'b0}}};

  logic [SW-1:0]        raw_in, syn_in;
  logic                 ca_s, cb_s, por_s;
  logic [NUM_RAILS-1:0] uvlo_s, ocp_s, olow_s;
  logic                 arm_ok, por_low, uvlo_any, ocp_any, all_low;
  logic                 conn_active, conn_done, por_qual;
  logic                 trip, trip_set;
  hsw_state_e           state_q, state_d;

  assign raw_in = {conn_a_n, conn_b_n, por_req_n, uvlo_flag, ocp_flag, out_low_flag};

  hsw_sync #(.WIDTH(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(syn_in)
  );

  assign {ca_s, cb_s, por_s, uvlo_s, ocp_s, olow_s} = syn_in;

  assign uvlo_any = |uvlo_s;
  assign ocp_any  = |ocp_s;
  assign all_low  = &olow_s;
  assign por_low  = !por_s;
  assign arm_ok   = !ca_s && !cb_s && !uvlo_any;

  assign conn_active = arm_ok && (state_q == ST_IDLE || state_q == ST_QUALIFY);

  hsw_qual_timer #(.TICK_DIV(TICK_DIV), .QUAL_TICKS(QUAL_TICKS)) u_conn_tmr (
    .clk(clk), .rst_n(rst_n), .active_i(conn_active), .done_o(conn_done)
  );

  hsw_qual_timer #(.TICK_DIV(TICK_DIV), .QUAL_TICKS(QUAL_TICKS)) u_por_tmr (
    .clk(clk), .rst_n(rst_n), .active_i(por_low), .done_o(por_qual)
  );

  assign trip_set = ocp_any && (state_q == ST_RAMP_ON);

  hsw_breaker u_brk (
    .clk(clk), .rst_n(rst_n), .set_i(trip_set), .clr_i(por_low), .trip_o(trip)
  );

  always_comb begin
    state_d = state_q;
    if (por_qual) begin
      state_d = ST_DISCHARGE;
    end else begin
      case (state_q)
        ST_IDLE:      if (arm_ok) state_d = ST_QUALIFY;
        ST_QUALIFY:   if (!arm_ok) state_d = ST_IDLE;
                      else if (conn_done) state_d = ST_RAMP_ON;
        ST_RAMP_ON:   if (ocp_any) state_d = ST_FAULTED;
                      else if (!arm_ok) state_d = ST_IDLE;
        ST_FAULTED:   if (!trip && !por_low) state_d = ST_WAIT_TRIP;
        ST_DISCHARGE: if (!por_low) state_d = ST_WAIT_TRIP;
        ST_WAIT_TRIP: if (all_low) state_d = ST_IDLE;
        default:      state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign pump_en = (state_q == ST_RAMP_ON) && arm_ok && !ocp_any && !por_qual;
  assign fault_n = !trip;

  AST_PUMP_AFTER_QUALIFY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pump_en) |-> $past(state_q == ST_QUALIFY)); // R2
  AST_TRIP_PUMP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    trip |-> !pump_en); // R6
  AST_HARD_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    por_qual |=> (state_q == ST_DISCHARGE)); // R9
  AST_DISCHARGE_INTERLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT_TRIP && !all_low && !por_qual) |=> (state_q == ST_WAIT_TRIP)); // R10
endmodule

// File: tb/tb_hsw_seq_ctrl.sv
module tb_hsw_seq_ctrl;
  localparam int NR = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          conn_a_n, conn_b_n, por_req_n;
  logic [NR-1:0] uvlo_flag, ocp_flag, out_low_flag;
  logic          pump_en, fault_n;
  int            checks = 0;
  int            errors = 0;

  always #10 clk = ~clk;

  hsw_seq_ctrl #(.NUM_RAILS(NR), .TICK_DIV(4), .QUAL_TICKS(5)) dut (
    .clk(clk), .rst_n(rst_n), .conn_a_n(conn_a_n), .conn_b_n(conn_b_n),
    .por_req_n(por_req_n), .uvlo_flag(uvlo_flag), .ocp_flag(ocp_flag),
    .out_low_flag(out_low_flag), .pump_en(pump_en), .fault_n(fault_n)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; conn_a_n = 1'b1; conn_b_n = 1'b1; por_req_n = 1'b1;
    uvlo_flag = '0; ocp_flag = '0; out_low_flag = '1;
    cyc(3);
    chk(pump_en, 1'b0, "R1 pump in reset");
    chk(fault_n, 1'b1, "R1 fault in reset");
    rst_n = 1'b1;
    cyc(5);
    chk(pump_en, 1'b0, "R1 pump after reset");
    chk(fault_n, 1'b1, "R1 fault after reset");
  endtask

  task automatic t_qualify;
    conn_a_n = 1'b0; conn_b_n = 1'b0;
    cyc(20);
    chk(pump_en, 1'b0, "R2 pump before interval");
    cyc(4);
    chk(pump_en, 1'b1, "R2 pump after interval");
    out_low_flag = '0;
  endtask

  task automatic t_conn_drop;
    conn_a_n = 1'b1;
    cyc(3);
    chk(pump_en, 1'b0, "R4 pump after contact lost");
    out_low_flag = '1;
  endtask

  task automatic t_glitch;
    conn_a_n = 1'b0;
    cyc(15);
    conn_b_n = 1'b1;
    cyc(2);
    conn_b_n = 1'b0;
    cyc(18);
    chk(pump_en, 1'b0, "R3 interval restarted by glitch");
    cyc(6);
    chk(pump_en, 1'b1, "R3 pump after full interval");
    out_low_flag = '0;
  endtask

  task automatic t_uvlo;
    uvlo_flag = 2'b01;
    cyc(3);
    chk(pump_en, 1'b0, "R5 pump drops on lockout");
    cyc(40);
    chk(pump_en, 1'b0, "R5 lockout blocks qualification");
    uvlo_flag = '0;
    cyc(24);
    chk(pump_en, 1'b1, "R5 pump after lockout clears");
  endtask

  task automatic t_por_short;
    por_req_n = 1'b0;
    cyc(10);
    por_req_n = 1'b1;
    cyc(5);
    chk(pump_en, 1'b1, "R8 short reset pulse ignored");
    cyc(30);
    chk(pump_en, 1'b1, "R8 still powered later");
  endtask

  task automatic t_hard_reset;
    por_req_n = 1'b0;
    cyc(18);
    chk(pump_en, 1'b1, "R9 pump before request qualifies");
    cyc(6);
    chk(pump_en, 1'b0, "R9 pump off after hard reset");
    cyc(40);
    chk(pump_en, 1'b0, "R9 off while request held");
    chk(fault_n, 1'b1, "R9 no fault on hard reset");
    por_req_n = 1'b1;
    cyc(40);
    chk(pump_en, 1'b0, "R10 blocked until outputs discharge");
    out_low_flag = '1;
    cyc(18);
    chk(pump_en, 1'b0, "R10 requalification running");
    cyc(10);
    chk(pump_en, 1'b1, "R10 pump back after requalification");
    out_low_flag = '0;
  endtask

  task automatic t_fault;
    ocp_flag = 2'b10;
    cyc(4);
    chk(pump_en, 1'b0, "R6 pump off on overcurrent");
    chk(fault_n, 1'b0, "R6 fault asserted");
    ocp_flag = '0;
    cyc(40);
    chk(pump_en, 1'b0, "R6 pump stays off after flag clears");
    chk(fault_n, 1'b0, "R6 latch holds");
    por_req_n = 1'b0;
    cyc(4);
    chk(fault_n, 1'b1, "R7 latch cleared by request");
    por_req_n = 1'b1;
    cyc(40);
    chk(pump_en, 1'b0, "R11 blocked until outputs discharge");
    out_low_flag = '1;
    cyc(18);
    chk(pump_en, 1'b0, "R11 requalification running");
    cyc(10);
    chk(pump_en, 1'b1, "R11 pump back after requalification");
    chk(fault_n, 1'b1, "R11 fault stays released");
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_qualify();
    t_conn_drop();
    t_glitch();
    t_uvlo();
    t_por_short();
    t_hard_reset();
    t_fault();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule